// File: doc/BRIEF.md
# Sticky Clock-Loss Failover Monitor

This block supervises a primary oscillator clock (nominally 25 MHz) against a free-running internal RC clock (nominally 12.5 MHz). A divided toggle of the primary clock is carried into the RC domain and its transitions are counted over a fixed window of RC cycles. A window that sees fewer transitions than a programmable threshold means that the primary clock has stopped. A stop latches a loss condition and pulls the active-low safety error output low.

If software has set the switch-enable bit, the system clock is handed over to the RC clock through a glitch-free two-stage mux. The handover is one-way. A returning primary clock and a warm reset both leave the RC clock driving the system. Only power-on reset clears the loss latch, the enable bit and the threshold. A raw "primary alive" status is refreshed at the end of every window and is not sticky, so software can see that the primary clock has recovered while the failover stays in place.

The control FSM has four states. `ST_PRIMARY` is normal operation. `ST_FAULT_HOLD` means loss is latched and switching is not enabled. `ST_HANDOFF` means the RC side has been requested. `ST_ON_RC` means the RC clock is driving the system. The transitions are:
- PRIMARY→FAULT_HOLD on a failed window with the enable bit at 0.
- PRIMARY→HANDOFF on a failed window with the enable bit at 1.
- FAULT_HOLD→HANDOFF when software sets the enable bit.
- HANDOFF→ON_RC when the mux reports that the RC stage is enabled.
- No transition leaves ON_RC except power-on reset.

Top module: `clkloss_failover_top`

## Requirements
- R1: After power-on reset, the enable bit is 0, the threshold is its default (2), the loss flag is 0, `safety_err_n` is 1, `st_on_rc` is 0, `st_pri_alive` is 1, and `sys_clk` follows the primary clock.
- R2: A window of 16 RC cycles is evaluated using the synchronized toggle of the primary clock divided by 4 (about 8 transitions per window when healthy). A window with fewer transitions than the threshold sets the loss flag and drives `safety_err_n` low. A healthy primary never does this.
- R3: With the enable bit at 0, a detected loss does not move the mux. `st_on_rc` stays 0 and `sys_clk` stays on the (stopped) primary.
- R4: When the enable bit is 1 and loss is latched, whichever of the two came first, the mux selects the RC clock, `st_on_rc` becomes 1, and `sys_clk` runs at the RC rate.
- R5: Loss is sticky. When the primary returns, the loss flag, the low `safety_err_n` and the RC selection all remain.
- R6: `st_pri_alive` is the result of the most recent window. It goes to 0 while the primary is stopped and back to 1 once the primary toggles again, even with loss latched.
- R7: Warm reset changes none of the enable bit, threshold, loss flag, error output or clock selection.
- R8: Power-on reset clears the loss flag, enable bit and selection, restores `safety_err_n` to 1 and returns `sys_clk` to the primary clock.
- R9: The two mux enable stages are never on together. A stopped primary stage is released after a timeout of 8 RC cycles, with no edge needed from the dead clock.
- R10: The threshold is `reg_wdata[5:1]` and is written when `reg_wr` is high. A threshold of 15 makes a healthy primary count as lost.
- R11: The enable bit is `reg_wdata[0]` and is set-only. Writing 0 does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary oscillator clock |
| clk_rc | input | 1 | Free-running RC reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low, sampled in RC domain |
| reg_wr | input | 1 | Register write strobe (RC domain) |
| reg_wdata | input | 6 | Bit 0 sets the enable bit; bits 5:1 set the threshold |
| sys_clk | output | 1 | Glitch-free system clock |
| safety_err_n | output | 1 | Active-low sticky safety error |
| st_sw_en | output | 1 | Enable bit read-back |
| st_loss | output | 1 | Sticky loss flag |
| st_pri_alive | output | 1 | Raw result of the last window |
| st_on_rc | output | 1 | RC mux stage is enabled |

## Verification
The bench stops the primary clock with the enable bit at 0. A design that switched anyway would show RC-rate edges on `sys_clk`. It then enables switching after the loss. A design that sampled the enable bit only at the moment of detection would stay in the hold state forever.

Restarting the primary clock exposes any design that cleared the latch or swapped back. The `sys_clk` edge count would return to the primary rate while `st_pri_alive` correctly shows 1. A warm reset pulse catches state wrongly tied to that reset.

Failover is tried both with the primary stopped (the timeout release) and with the primary still running under an excessive threshold. A mux that waited for an edge from the dead clock would never report `st_on_rc`. Writing 0 to the enable bit catches a design that lets software clear it.

// File: rtl/clkloss_pkg.sv
package clkloss_pkg;
    typedef enum logic [1:0] {
        ST_PRIMARY    = 2'd0,
        ST_FAULT_HOLD = 2'd1,
        ST_HANDOFF    = 2'd2,
        ST_ON_RC      = 2'd3
    } fo_state_t;
endpackage

// File: rtl/clkloss_edge_monitor.sv
module clkloss_edge_monitor #(
    parameter int WIN     = 16,
    parameter int PRI_DIV = 4,
    parameter int CNT_W   = $clog2(WIN + 1)
) (
    input  logic             clk_pri,
    input  logic             clk_rc,
    input  logic             por_n,
    input  logic             warm_rst_n,
    input  logic [CNT_W-1:0] thresh,
    output logic             win_fail,
    output logic             pri_alive
);
    localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int DIV_W = (PRI_DIV > 1) ? $clog2(PRI_DIV) : 1;

    logic [DIV_W-1:0] div_q;
    logic             tog_q;

    // primary domain: divided toggle
    always_ff @(posedge clk_pri or negedge por_n) begin
        if (!por_n) begin
            div_q <= '0;
            tog_q <= 1'b0;
        end else if (div_q == DIV_W'(PRI_DIV - 1)) begin
            div_q <= '0;
            tog_q <= ~tog_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // RC domain: synchronizer and transition detect
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_rc or negedge por_n) begin
        if (!por_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= tog_q;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    logic chg;
    assign chg = s2_q ^ s3_q;

    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   total;
    logic             last;
    logic             short_win;

    assign last      = (win_q == WIN_W'(WIN - 1));
    assign total     = {1'b0, cnt_q} + {{CNT_W{1'b0}}, chg};
    assign short_win = total < {1'b0, thresh};

    always_ff @(posedge clk_rc or negedge por_n) begin
        if (!por_n) begin
            win_q     <= '0;
            cnt_q     <= '0;
            win_fail  <= 1'b0;
            pri_alive <= 1'b1;
        end else if (!warm_rst_n) begin
            win_q    <= '0;
            cnt_q    <= '0;
            win_fail <= 1'b0;
        end else begin
            win_fail <= 1'b0;
            if (last) begin
                win_q     <= '0;
                cnt_q     <= '0;
                win_fail  <= short_win;
                pri_alive <= ~short_win;
            end else begin
                win_q <= win_q + 1'b1;
                if (chg && (cnt_q != CNT_W'(WIN)))
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2: a failure verdict is only issued right after a window's last cycle
    p_fail_at_window_end_r2: assert property (@(posedge clk_rc) disable iff (!por_n)
        win_fail |-> $past(last));

    // R2: the transition count never exceeds the window length
    p_count_bound_r2: assert property (@(posedge clk_rc) disable iff (!por_n)
        cnt_q <= CNT_W'(WIN));
endmodule

// File: rtl/clkloss_clk_mux.sv
module clkloss_clk_mux #(
    parameter int KILL_CYC = 8
) (
    input  logic clk_pri,
    input  logic clk_rc,
    input  logic por_n,
    input  logic sel_rc,
    output logic sys_clk,
    output logic rc_active
);
    localparam int KILL_W = $clog2(KILL_CYC + 1);

    logic en_pri;
    logic en_rc;
    logic kill_q;
    logic sel_p1, sel_p2;
    logic pe_s1, pe_s2;
    logic [KILL_W-1:0] kill_cnt;

    // primary stage: synchronize the RC request on the primary's falling edge
    always_ff @(negedge clk_pri or negedge por_n) begin
        if (!por_n) begin
            sel_p1 <= 1'b0;
            sel_p2 <= 1'b0;
        end else begin
            sel_p1 <= sel_rc;
            sel_p2 <= sel_p1;
        end
    end

    // primary enable: cleared by its own clock when alive, or by the timeout when dead
    always_ff @(negedge clk_pri or negedge por_n or posedge kill_q) begin
        if (!por_n)
            en_pri <= 1'b1;
        else if (kill_q)
            en_pri <= 1'b0;
        else if (sel_p2)
            en_pri <= 1'b0;
    end

    // RC stage: observe the primary enable, then enable on RC falling edge
    always_ff @(negedge clk_rc or negedge por_n) begin
        if (!por_n) begin
            pe_s1 <= 1'b1;
            pe_s2 <= 1'b1;
            en_rc <= 1'b0;
        end else begin
            pe_s1 <= en_pri;
            pe_s2 <= pe_s1;
            en_rc <= sel_rc & ~pe_s2;
        end
    end

    // release timeout for a stopped primary
    always_ff @(posedge clk_rc or negedge por_n) begin
        if (!por_n) begin
            kill_cnt <= '0;
            kill_q   <= 1'b0;
        end else if (sel_rc && pe_s2 && !kill_q) begin
            if (kill_cnt == KILL_W'(KILL_CYC - 1))
                kill_q <= 1'b1;
            else
                kill_cnt <= kill_cnt + 1'b1;
        end
    end

    assign sys_clk   = (clk_pri & en_pri) | (clk_rc & en_rc);
    assign rc_active = en_rc;

    // R9: the two enable stages are never on together
    p_stage_exclusive_r9: assert property (@(posedge clk_rc) disable iff (!por_n)
        en_rc |-> !en_pri);

    // R9: the RC stage is only enabled on request
    p_rc_needs_req_r9: assert property (@(posedge clk_rc) disable iff (!por_n)
        en_rc |-> sel_rc);
endmodule

// File: rtl/clkloss_ctrl.sv
module clkloss_ctrl
    import clkloss_pkg::*;
#(
    parameter int CNT_W      = 5,
    parameter int THRESH_DEF = 2
) (
    input  logic             clk_rc,
    input  logic             por_n,
    input  logic             reg_wr,
    input  logic [CNT_W:0]   reg_wdata,
    input  logic             win_fail,
    input  logic             rc_active,
    output logic             sw_en,
    output logic [CNT_W-1:0] thresh,
    output logic             sel_rc,
    output logic             loss,
    output logic             err_n
);
    fo_state_t state_q, state_d;

    // registers cleared only by power-on reset
    always_ff @(posedge clk_rc or negedge por_n) begin
        if (!por_n) begin
            sw_en  <= 1'b0;
            thresh <= CNT_W'(THRESH_DEF);
        end else if (reg_wr) begin
            if (reg_wdata[0])
                sw_en <= 1'b1;
            thresh <= reg_wdata[CNT_W:1];
        end
    end

    // state register
    always_ff @(posedge clk_rc or negedge por_n) begin
        if (!por_n)
            state_q <= ST_PRIMARY;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIMARY: begin
                if (win_fail)
                    state_d = sw_en ? ST_HANDOFF : ST_FAULT_HOLD;
            end
            ST_FAULT_HOLD: begin
                if (sw_en)
                    state_d = ST_HANDOFF;
            end
            ST_HANDOFF: begin
                if (rc_active)
                    state_d = ST_ON_RC;
            end
            ST_ON_RC: state_d = ST_ON_RC;
            default:  state_d = ST_PRIMARY;
        endcase
    end

    // outputs
    always_comb begin
        sel_rc = 1'b0;
        loss   = 1'b1;
        err_n  = 1'b0;
        unique case (state_q)
            ST_PRIMARY: begin
                loss  = 1'b0;
                err_n = 1'b1;
            end
            ST_FAULT_HOLD: sel_rc = 1'b0;
            ST_HANDOFF:    sel_rc = 1'b1;
            ST_ON_RC:      sel_rc = 1'b1;
            default: begin
                loss  = 1'b0;
                err_n = 1'b1;
            end
        endcase
    end

    // R3: the RC clock is never requested without the enable bit
    p_sel_needs_en_r3: assert property (@(posedge clk_rc) disable iff (!por_n)
        sel_rc |-> sw_en);

    // R5: loss and RC selection are sticky
    p_loss_sticky_r5: assert property (@(posedge clk_rc) disable iff (!por_n)
        loss |=> loss);
    p_sel_sticky_r5: assert property (@(posedge clk_rc) disable iff (!por_n)
        sel_rc |=> sel_rc);

    // R11: the enable bit is never cleared outside power-on reset
    p_en_set_only_r11: assert property (@(posedge clk_rc) disable iff (!por_n)
        sw_en |=> sw_en);

    // R2: the error output falls only after a failed window verdict
    p_err_from_fail_r2: assert property (@(posedge clk_rc) disable iff (!por_n)
        $fell(err_n) |-> $past(win_fail));
endmodule

// File: rtl/clkloss_failover_top.sv
module clkloss_failover_top #(
    parameter int WIN        = 16,
    parameter int PRI_DIV    = 4,
    parameter int THRESH_DEF = 2,
    parameter int KILL_CYC   = 8
) (
    input  logic                     clk_pri,
    input  logic                     clk_rc,
    input  logic                     por_n,
    input  logic                     warm_rst_n,
    input  logic                     reg_wr,
    input  logic [$clog2(WIN+1):0]   reg_wdata,
    output logic                     sys_clk,
    output logic                     safety_err_n,
    output logic                     st_sw_en,
    output logic                     st_loss,
    output logic                     st_pri_alive,
    output logic                     st_on_rc
);
    localparam int CNT_W = $clog2(WIN + 1);

    logic             win_fail;
    logic             rc_active;
    logic             sel_rc;
    logic [CNT_W-1:0] thresh;

    clkloss_edge_monitor #(
        .WIN     (WIN),
        .PRI_DIV (PRI_DIV),
        .CNT_W   (CNT_W)
    ) u_mon (
        .clk_pri    (clk_pri),
        .clk_rc     (clk_rc),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .thresh     (thresh),
        .win_fail   (win_fail),
        .pri_alive  (st_pri_alive)
    );

    clkloss_ctrl #(
        .CNT_W      (CNT_W),
        .THRESH_DEF (THRESH_DEF)
    ) u_ctrl (
        .clk_rc    (clk_rc),
        .por_n     (por_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .win_fail  (win_fail),
        .rc_active (rc_active),
        .sw_en     (st_sw_en),
        .thresh    (thresh),
        .sel_rc    (sel_rc),
        .loss      (st_loss),
        .err_n     (safety_err_n)
    );

    clkloss_clk_mux #(
        .KILL_CYC (KILL_CYC)
    ) u_mux (
        .clk_pri   (clk_pri),
        .clk_rc    (clk_rc),
        .por_n     (por_n),
        .sel_rc    (sel_rc),
        .sys_clk   (sys_clk),
        .rc_active (rc_active)
    );

    assign st_on_rc = rc_active;

    // R7: warm reset leaves the enable bit, loss flag and selection alone
    p_warm_keeps_en_r7: assert property (@(posedge clk_rc) disable iff (!por_n)
        (!warm_rst_n && st_sw_en) |=> st_sw_en);
    p_warm_keeps_loss_r7: assert property (@(posedge clk_rc) disable iff (!por_n)
        (!warm_rst_n && st_loss) |=> (st_loss && !safety_err_n));
    p_warm_keeps_rc_r7: assert property (@(posedge clk_rc) disable iff (!por_n)
        (!warm_rst_n && st_on_rc) |=> st_on_rc);
endmodule

// File: tb/sim_clkloss_failover_top.sv
module sim_clkloss_failover_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic clk_pri = 1'b0;
    logic clk_rc  = 1'b0;
    logic pri_on  = 1'b1;
    logic [1:0] pri_div = '0;
    logic [2:0] rc_div  = '0;

    always @(posedge clk) begin
        pri_div <= pri_div + 1'b1;
        if (pri_div[0]) clk_pri <= pri_on ? ~clk_pri : 1'b0;
        rc_div <= rc_div + 1'b1;
        if (rc_div[1:0] == 2'd3) clk_rc <= ~clk_rc;
    end

    logic       por_n      = 1'b0;
    logic       warm_rst_n = 1'b1;
    logic       reg_wr     = 1'b0;
    logic [5:0] reg_wdata  = '0;
    logic sys_clk, safety_err_n, st_sw_en, st_loss, st_pri_alive, st_on_rc;

    clkloss_failover_top u0 (
        .clk_pri      (clk_pri),
        .clk_rc       (clk_rc),
        .por_n        (por_n),
        .warm_rst_n   (warm_rst_n),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .sys_clk      (sys_clk),
        .safety_err_n (safety_err_n),
        .st_sw_en     (st_sw_en),
        .st_loss      (st_loss),
        .st_pri_alive (st_pri_alive),
        .st_on_rc     (st_on_rc)
    );

    int checks = 0;
    int errors = 0;
    int edge_cnt = 0;
    int cyc = 0;

    always @(posedge sys_clk) edge_cnt++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    // count sys_clk rising edges over 1600 ns: primary ~40, RC ~20
    task automatic sys_edges(output int n);
        int start;
        @(negedge clk);
        start = edge_cnt;
        #1600;
        n = edge_cnt - start;
    endtask

    task automatic wr(input logic [5:0] d);
        @(negedge clk_rc);
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk_rc);
        reg_wr    = 1'b0;
    endtask

    task automatic do_por();
        por_n = 1'b0;
        pri_on = 1'b1;
        repeat (4) @(negedge clk_rc);
        por_n = 1'b1;
        #2000;
        @(negedge clk);
    endtask

    task automatic t_reset();
        int n;
        do_por();
        chk("R1 enable bit", st_sw_en, 0);
        chk("R1 loss flag", st_loss, 0);
        chk("R1 error output", safety_err_n, 1);
        chk("R1 on rc", st_on_rc, 0);
        chk("R1 alive", st_pri_alive, 1);
        sys_edges(n);
        chk_rng("R1 sys_clk primary rate", n, 38, 42);
    endtask

    task automatic t_healthy();
        #8000;
        @(negedge clk);
        chk("R2 healthy no loss", st_loss, 0);
        chk("R2 healthy error high", safety_err_n, 1);
    endtask

    task automatic t_loss_no_enable();
        int n;
        pri_on = 1'b0;
        #4000;
        @(negedge clk);
        chk("R2 loss flagged", st_loss, 1);
        chk("R2 error low", safety_err_n, 0);
        chk("R3 no switch without enable", st_on_rc, 0);
        chk("R6 alive low while stopped", st_pri_alive, 0);
        sys_edges(n);
        chk("R3 sys_clk stays on dead primary", n, 0);
    endtask

    task automatic t_enable_late();
        int n;
        wr(6'b000101);   // threshold 2, enable 1
        #2000;
        @(negedge clk);
        chk("R4 enable bit set", st_sw_en, 1);
        chk("R4 on rc after late enable", st_on_rc, 1);
        sys_edges(n);
        chk_rng("R4 sys_clk rc rate", n, 18, 22);
    endtask

    task automatic t_recover();
        int n;
        pri_on = 1'b1;
        #4000;
        @(negedge clk);
        chk("R5 loss stays", st_loss, 1);
        chk("R5 error stays low", safety_err_n, 0);
        chk("R5 stays on rc", st_on_rc, 1);
        chk("R6 alive after recovery", st_pri_alive, 1);
        sys_edges(n);
        chk_rng("R5 sys_clk still rc rate", n, 18, 22);
    endtask

    task automatic t_warm();
        int n;
        @(negedge clk_rc);
        warm_rst_n = 1'b0;
        repeat (3) @(negedge clk_rc);
        warm_rst_n = 1'b1;
        #3000;
        @(negedge clk);
        chk("R7 enable kept", st_sw_en, 1);
        chk("R7 loss kept", st_loss, 1);
        chk("R7 error kept", safety_err_n, 0);
        chk("R7 rc kept", st_on_rc, 1);
        sys_edges(n);
        chk_rng("R7 sys_clk rc rate", n, 18, 22);
    endtask

    task automatic t_por_clear();
        int n;
        do_por();
        chk("R8 enable cleared", st_sw_en, 0);
        chk("R8 loss cleared", st_loss, 0);
        chk("R8 error high", safety_err_n, 1);
        chk("R8 off rc", st_on_rc, 0);
        sys_edges(n);
        chk_rng("R8 sys_clk primary rate", n, 38, 42);
    endtask

    task automatic t_dead_release();
        int n;
        wr(6'b000101);
        wr(6'b000100);   // write 0 to the enable bit
        @(negedge clk);
        chk("R11 enable not cleared by 0", st_sw_en, 1);
        pri_on = 1'b0;
        #5000;
        @(negedge clk);
        chk("R9 dead primary released, on rc", st_on_rc, 1);
        chk("R4 loss with enable first", st_loss, 1);
        sys_edges(n);
        chk_rng("R9 sys_clk rc rate", n, 18, 22);
    endtask

    task automatic t_threshold();
        int n;
        wr(6'b011111);   // threshold 15, enable 1
        #4000;
        @(negedge clk);
        chk("R10 high threshold flags loss", st_loss, 1);
        chk("R10 healthy reads not alive", st_pri_alive, 0);
        chk("R9 live primary handoff", st_on_rc, 1);
        sys_edges(n);
        chk_rng("R10 sys_clk rc rate", n, 18, 22);
    endtask

    initial begin
        t_reset();
        t_healthy();
        t_loss_no_enable();
        t_enable_late();
        t_recover();
        t_warm();
        t_por_clear();
        t_dead_release();
        do_por();
        t_threshold();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule